// File: doc/BRIEF.md
# HDB3/AMI Line Decoder with Code-Violation Check

This block is the receive half of a bipolar line interface. An external line receiver splits the ternary line signal into two unipolar inputs, one for positive marks and one for negative marks. The block samples them on the receive clock and rebuilds the NRZ data stream.

In HDB3 mode it finds each four-bit zero substitution by its violation mark and returns those four bit positions to zeros. In AMI mode every mark decodes to a one. In either mode it raises a one-period error flag for every received bit that breaks the coding rules. It also drives a recovered-clock indication, which external clock-extraction circuitry can use.

A loop-test input replaces the external line inputs with the outputs of the companion encoder. The transmit and receive paths can then be checked end to end without a line.

Top module: `hdb3_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, nrz_out and code_err are 0. Reset clears the record of the previous mark and of the previous violation.
- R2: A line bit sampled at rising edge n, and not removed by R5, appears on nrz_out after rising edge n+3 and holds there for one clock period.
- R3: With hdb3_mode low (AMI), a bit with exactly one input high decodes to 1 and a bit with both inputs low decodes to 0. The positive input is rx_pos (or lb_pos) and the negative input is rx_neg (or lb_neg).
- R4: In AMI mode, a single-input mark with the same polarity as the preceding single-input mark is a coding error, and it still decodes to 1. A bit with both inputs low never raises an error.
- R5: With hdb3_mode high, a single-input mark with the same polarity as the preceding single-input mark is a violation. That bit and the three bit positions sampled before it are output as 0.
- R6: In HDB3 mode, a violation whose polarity equals the polarity of the previous violation is a coding error. The first violation after reset is not an error, and neither is a violation of opposite polarity to the previous one.
- R7: A bit with both inputs high is a coding error and decodes to 1. It changes neither the previous-mark nor the previous-violation record.
- R8: rclk_ind is the combinational OR of the two selected inputs, with no register in the path.
- R9: With loop_en high, lb_pos and lb_neg feed the decoder and rclk_ind. The values on rx_pos and rx_neg have no effect on any output.
- R10: code_err for the bit sampled at rising edge n is high from edge n to edge n+1, so each offending bit gives exactly one period of error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | External positive-mark line input |
| rx_neg | input | 1 | External negative-mark line input |
| lb_pos | input | 1 | Companion encoder positive-mark output, used in loop test |
| lb_neg | input | 1 | Companion encoder negative-mark output, used in loop test |
| loop_en | input | 1 | 1 selects the loop-back inputs in place of the line inputs |
| hdb3_mode | input | 1 | 1 selects HDB3 decoding, 0 selects AMI decoding |
| nrz_out | output | 1 | Decoded NRZ data |
| code_err | output | 1 | One-period flag for each bit that breaks the coding rules |
| rclk_ind | output | 1 | OR of the two selected inputs |

## Verification
Each result has its own due time, counted from the rising edge that samples a bit. code_err for that bit is due right after the same edge, and its decoded value is due on nrz_out after the third edge that follows. rclk_ind is due as soon as the inputs settle, before any edge. The bench drives each symbol at a falling edge and checks rclk_ind one nanosecond later. At the next falling edge it compares code_err against the symbol just sampled and nrz_out against the symbol sampled three edges earlier. The whole expected stream for a run is worked out first, so that a violation can blank bits that were sampled before it.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

   // line symbol: bit 0 = positive input, bit 1 = negative input
   typedef enum logic [1:0] {
      SYM_SPACE = 2'b00,
      SYM_PLUS  = 2'b01,
      SYM_MINUS = 2'b10,
      SYM_CLASH = 2'b11
   } sym_t;

endpackage

// File: rtl/hdb3_rx_sel.sv
module hdb3_rx_sel
   import hdb3_rx_pkg::*;
(
   input  logic rx_pos,
   input  logic rx_neg,
   input  logic lb_pos,
   input  logic lb_neg,
   input  logic loop_en,
   output sym_t sym,
   output logic rclk_ind
);

   logic sel_pos;
   logic sel_neg;

   // loop test replaces the line receiver with the encoder outputs
   assign sel_pos  = loop_en ? lb_pos : rx_pos;
   assign sel_neg  = loop_en ? lb_neg : rx_neg;
   assign sym      = sym_t'({sel_neg, sel_pos});
   assign rclk_ind = sel_pos | sel_neg;

endmodule

// File: rtl/hdb3_rx_rule.sv
module hdb3_rx_rule
   import hdb3_rx_pkg::*;
#(
   parameter bit HDB3_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  sym_t sym,
   input  logic hdb3_mode,
   output logic bit_d,
   output logic clr_d,
   output logic err_q
);

   logic mark_seen, mark_neg;
   logic viol_seen, viol_neg;
   logic single, pol_neg, repeat_pol, hdb3_act, viol, err_d;

   generate
      if (HDB3_EN) begin : g_hdb3
         assign hdb3_act = hdb3_mode;
      end else begin : g_ami_only
         assign hdb3_act = 1'b0;
      end
   endgenerate

   assign single     = (sym == SYM_PLUS) || (sym == SYM_MINUS);
   assign pol_neg    = (sym == SYM_MINUS);
   assign repeat_pol = single && mark_seen && (pol_neg == mark_neg);
   assign viol       = repeat_pol && hdb3_act;

   always_comb begin
      err_d = 1'b0;
      if (sym == SYM_CLASH)
         err_d = 1'b1;
      else if (repeat_pol && !hdb3_act)
         err_d = 1'b1;
      else if (viol && viol_seen && (pol_neg == viol_neg))
         err_d = 1'b1;
   end

   assign bit_d = (sym != SYM_SPACE) && !viol;
   assign clr_d = viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_seen <= 1'b0;
         mark_neg  <= 1'b0;
         viol_seen <= 1'b0;
         viol_neg  <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         err_q <= err_d;
         if (single) begin
            mark_seen <= 1'b1;
            mark_neg  <= pol_neg;
         end
         if (viol) begin
            viol_seen <= 1'b1;
            viol_neg  <= pol_neg;
         end
      end
   end

endmodule

// File: rtl/hdb3_rx_dly.sv
module hdb3_rx_dly #(
   parameter int DEPTH    = 4,
   parameter int CLR_SPAN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_d,
   input  logic clr_d,
   output logic bit_q
);

   logic [DEPTH-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[0] <= 1'b0;
      else        sr[0] <= bit_d;
   end

   genvar k;
   generate
      for (k = 1; k < DEPTH; k++) begin : g_stage
         if (k <= CLR_SPAN) begin : g_clearable
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     sr[k] <= 1'b0;
               else if (clr_d) sr[k] <= 1'b0;
               else            sr[k] <= sr[k-1];
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[k] <= 1'b0;
               else        sr[k] <= sr[k-1];
            end
         end
      end
   endgenerate

   assign bit_q = sr[DEPTH-1];

endmodule

// File: rtl/hdb3_rx.sv
module hdb3_rx
   import hdb3_rx_pkg::*;
#(
   parameter int ZERO_SPAN = 3,
   parameter int EXTRA_DLY = 0,
   parameter bit HDB3_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_pos,
   input  logic rx_neg,
   input  logic lb_pos,
   input  logic lb_neg,
   input  logic loop_en,
   input  logic hdb3_mode,
   output logic nrz_out,
   output logic code_err,
   output logic rclk_ind
);

   localparam int DEPTH = ZERO_SPAN + 1 + EXTRA_DLY;

   generate
      if (ZERO_SPAN < 1) begin : g_bad_span
         $error("hdb3_rx: ZERO_SPAN must be at least 1");
      end
      if (EXTRA_DLY < 0) begin : g_bad_dly
         $error("hdb3_rx: EXTRA_DLY must not be negative");
      end
   endgenerate

   sym_t sym;
   logic bit_d, clr_d;

   hdb3_rx_sel u_sel (
      .rx_pos   (rx_pos),
      .rx_neg   (rx_neg),
      .lb_pos   (lb_pos),
      .lb_neg   (lb_neg),
      .loop_en  (loop_en),
      .sym      (sym),
      .rclk_ind (rclk_ind)
   );

   hdb3_rx_rule #(.HDB3_EN(HDB3_EN)) u_rule (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym       (sym),
      .hdb3_mode (hdb3_mode),
      .bit_d     (bit_d),
      .clr_d     (clr_d),
      .err_q     (code_err)
   );

   hdb3_rx_dly #(.DEPTH(DEPTH), .CLR_SPAN(ZERO_SPAN)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .bit_d (bit_d),
      .clr_d (clr_d),
      .bit_q (nrz_out)
   );

endmodule

// File: rtl/hdb3_rx_chk.sv
module hdb3_rx_chk #(
   parameter int ZERO_SPAN = 3,
   parameter int EXTRA_DLY = 0
) (
   input logic clk,
   input logic rst_n,
   input logic rx_pos,
   input logic rx_neg,
   input logic lb_pos,
   input logic lb_neg,
   input logic loop_en,
   input logic hdb3_mode,
   input logic nrz_out,
   input logic code_err,
   input logic rclk_ind
);

   localparam int DEPTH = ZERO_SPAN + 1 + EXTRA_DLY;

   logic p, n;
   assign p = loop_en ? lb_pos : rx_pos;
   assign n = loop_en ? lb_neg : rx_neg;

   // marks and spaces sampled in AMI mode, aged to the output position
   logic [DEPTH-1:0] ami_one, ami_zero;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ami_one  <= '0;
         ami_zero <= '0;
      end else begin
         ami_one  <= {ami_one[DEPTH-2:0],  !hdb3_mode && (p != n)};
         ami_zero <= {ami_zero[DEPTH-2:0], !hdb3_mode && !p && !n};
      end
   end

   AST_SPACE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!p && !n) |=> !code_err); // R4

   AST_CLASH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (p && n) |=> code_err); // R7

   AST_RCLK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (p || n) |-> rclk_ind); // R8

   AST_LOOP_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && !lb_pos && !lb_neg) |-> !rclk_ind); // R9

   AST_AMI_MARK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ami_one[DEPTH-1] |-> nrz_out); // R3

   AST_AMI_SPACE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ami_zero[DEPTH-1] |-> !nrz_out); // R2

endmodule

bind hdb3_rx hdb3_rx_chk #(.ZERO_SPAN(ZERO_SPAN), .EXTRA_DLY(EXTRA_DLY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_pos    (rx_pos),
   .rx_neg    (rx_neg),
   .lb_pos    (lb_pos),
   .lb_neg    (lb_neg),
   .loop_en   (loop_en),
   .hdb3_mode (hdb3_mode),
   .nrz_out   (nrz_out),
   .code_err  (code_err),
   .rclk_ind  (rclk_ind)
);

// File: tb/hdb3_rx_tb.sv
`timescale 1ns/1ps
module hdb3_rx_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_pos = 1'b0, rx_neg = 1'b0, lb_pos = 1'b0, lb_neg = 1'b0;
   logic loop_en = 1'b0, hdb3_mode = 1'b0;
   logic nrz_out, code_err, rclk_ind;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   hdb3_rx u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_pos(rx_pos), .rx_neg(rx_neg), .lb_pos(lb_pos), .lb_neg(lb_neg),
      .loop_en(loop_en), .hdb3_mode(hdb3_mode),
      .nrz_out(nrz_out), .code_err(code_err), .rclk_ind(rclk_ind)
   );

   localparam int LEN = 5;
   localparam int RUN = LEN + 3;

   int sy [RUN];
   int exo[RUN];
   int exe[RUN];

   task automatic check(string tag, int got, int exp, int code);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s code=%0d hdb3=%0d loop=%0d got %0d expected %0d",
                  tag, code, hdb3_mode, loop_en, got, exp);
      end
   endtask

   // expected stream built from the requirements
   task automatic model(int code, bit mode);
      bit ms = 0, mn = 0, vs = 0, vn = 0;
      for (int i = 0; i < RUN; i++) begin
         sy[i]  = (i < LEN) ? ((code >> (2 * i)) & 3) : 0;
         exo[i] = 0;
         exe[i] = 0;
      end
      for (int i = 0; i < RUN; i++) begin
         if (sy[i] == 3) begin
            exo[i] = 1; exe[i] = 1;                    // R7
         end else if (sy[i] != 0) begin
            bit neg = (sy[i] == 2);
            bit rep = ms && (neg == mn);
            if (rep && mode) begin                     // R5
               for (int k = 0; k <= 3; k++)
                  if (i - k >= 0) exo[i-k] = 0;
               exe[i] = (vs && (neg == vn)) ? 1 : 0;   // R6
               vs = 1; vn = neg;
            end else begin
               exo[i] = 1;
               exe[i] = rep ? 1 : 0;                   // R4
            end
            ms = 1; mn = neg;
         end
      end
   endtask

   task automatic run(int code, bit mode, bit lp);
      string etag, otag;
      model(code, mode);
      etag = mode ? "R6" : "R4";
      otag = mode ? "R5" : "R3";
      @(negedge clk);
      rst_n = 1'b0; hdb3_mode = mode; loop_en = lp;
      rx_pos = 1'b0; rx_neg = 1'b0; lb_pos = 1'b0; lb_neg = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 nrz", nrz_out, 0, code);
      check("R1 err", code_err, 0, code);
      for (int i = 0; i < RUN; i++) begin
         logic p, q;
         p = sy[i][0]; q = sy[i][1];
         if (lp) begin
            lb_pos = p; lb_neg = q; rx_pos = ~p; rx_neg = q ^ p;
         end else begin
            rx_pos = p; rx_neg = q; lb_pos = ~q; lb_neg = ~p;
         end
         #1;
         check(lp ? "R9 rclk" : "R8 rclk", rclk_ind, p | q, code);
         @(posedge clk);
         @(negedge clk);
         check(sy[i] == 3 ? "R7 err" : (lp ? "R9 err" : etag), code_err, exe[i], code);
         if (i >= 3)
            check(lp ? "R9 nrz" : otag, nrz_out, exo[i-3], code);
         else
            check("R2 nrz", nrz_out, 0, code);
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++;
      $display("FAIL watchdog R10 got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R10: every error check lands exactly one edge after sampling
      for (int m = 0; m < 2; m++)
         for (int l = 0; l < 2; l++)
            for (int c = 0; c < (1 << (2 * LEN)); c++)
               run(c, m[0], l[0]);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule